// File: doc/BRIEF.md
# Programmable priority interrupt resolver

This block sits behind the pending-bit storage and masking logic of an interrupt controller. It receives the already-masked 21-bit pending vector and a per-source mode vector, where a 1 marks a source that is served on the fast interrupt line and a 0 marks one served on the normal line. From these it works out which pending source currently has the highest priority. The priority order is not fixed. Software assigns it by writing a source index into each of 21 priority slots, and a higher slot number means a higher priority.

The slots and the results are reached through a simple register bus. The slots are packed four to a 32-bit word. Three read-only words give the winning source as its index shifted left by two: one winner over all sources, one over fast-mode sources only, and one over normal-mode sources only. When nothing qualifies, these words read the code 0x54, which can never be confused with source 0. A fourth read-only word holds the pending vector reordered into slot order.

The resolution itself is combinational. A read is captured into a data register on the clock edge where it is requested, and `bus_rvalid_o` marks the following cycle. A two-state machine controls this. In `BUS_IDLE` no read data is presented. A read request takes the transition *accept* into `BUS_RESP`. From `BUS_RESP`, a further read request takes *chain* and stays in `BUS_RESP`, and no request takes *release* back to `BUS_IDLE`.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset, slot n holds index n. The slot words therefore read 0x03020100 at 0x0C, 0x07060504 at 0x10, 0x0B0A0908 at 0x14, 0x0F0E0D0C at 0x18, 0x13121110 at 0x1C and 0x00000014 at 0x20.
- R2: Slot 4k+j sits in byte j (bits 8j+7:8j) of the word at 0x0C+4k. Only the low 5 bits of each byte are kept and the other bits read as 0. The word at 0x20 holds slot 20 alone, so its bytes 1 to 3 always read 0.
- R3: The word at 0x28 has bit n equal to the pending bit of the source whose index is in slot n, or 0 when that index is 21 or more.
- R4: The word at 0x24 reads (s << 2), where s is the index stored in the highest-numbered slot whose source is pending.
- R5: When no pending source qualifies, each offset word (0x24, 0x30, 0x34) reads 0x54. A lone pending source 0 reads 0x00.
- R6: The word at 0x30 resolves among pending sources whose mode bit is 1 only. The word at 0x34 resolves among pending sources whose mode bit is 0 only. Both use the same rule as R4.
- R7: A slot holding an index of 21 or more never wins. When one index is stored in two slots, the higher slot sets that source's priority.
- R8: Data for a read requested at a clock edge appears on `bus_rdata_o` after that edge, with `bus_rvalid_o` high for exactly that cycle per request. Unmapped addresses read 0. Writes to the read-only words and to unmapped addresses change nothing. `bus_rdata_o` holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pend_i | input | 21 | Masked pending bit per source |
| src_fast_i | input | 21 | Mode per source: 1 for fast, 0 for normal |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | 8 | Byte address of the word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| bus_rvalid_o | output | 1 | High in the cycle after an accepted read |

## Verification
The bench builds the block with its default parameters: 21 sources, 5-bit slot fields, an 8-bit address and a 32-bit word. With these values the last slot word is only partly filled. They also leave room for indices 21 to 31 to be stored but never matched, so the out-of-range and upper-lane cases of R2 and R7 can be reached directly. Random slot words mix legal indices, out-of-range indices and duplicated indices, and random pending and mode vectors exercise all three offset groups against a slot map that the bench keeps for itself.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int NUM_SRC = 21;
    localparam int IDX_W   = 5;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int LANE_W  = 8;
    localparam int LANES   = DATA_W / LANE_W;

    // register layout (byte addresses)
    localparam int A_SLOT_BASE = 'h0C;
    localparam int A_OFF_ALL   = 'h24;
    localparam int A_BY_PRIO   = 'h28;
    localparam int A_OFF_FAST  = 'h30;
    localparam int A_OFF_NORM  = 'h34;

    localparam int NONE_CODE   = 'h54;

    typedef enum logic [1:0] {
        GRP_ALL  = 2'd0,
        GRP_FAST = 2'd1,
        GRP_NORM = 2'd2
    } grp_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/irq_slot_regs.sv
module irq_slot_regs #(
    parameter int NUM_SRC = irq_prio_pkg::NUM_SRC,
    parameter int IDX_W   = irq_prio_pkg::IDX_W,
    parameter int ADDR_W  = irq_prio_pkg::ADDR_W,
    parameter int DATA_W  = irq_prio_pkg::DATA_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic [NUM_SRC*IDX_W-1:0] slots_flat
);
    import irq_prio_pkg::*;

    localparam int SLOTS_PER_WORD = DATA_W / LANE_W;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_slot
        localparam int WORD = s / SLOTS_PER_WORD;
        localparam int LANE = s % SLOTS_PER_WORD;
        localparam logic [ADDR_W-1:0] WADDR = ADDR_W'(A_SLOT_BASE + 4 * WORD);
        localparam logic [IDX_W-1:0]  RST_IDX = IDX_W'(s);

        logic [IDX_W-1:0] slot_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= RST_IDX;
            end else if (wr_en && addr == WADDR) begin
                slot_q <= wdata[LANE*LANE_W +: IDX_W];
            end
        end

        assign slots_flat[s*IDX_W +: IDX_W] = slot_q;
    end

endmodule

// File: rtl/irq_prio_reorder.sv
module irq_prio_reorder #(
    parameter int NUM_SRC = irq_prio_pkg::NUM_SRC,
    parameter int IDX_W   = irq_prio_pkg::IDX_W
) (
    input  logic [NUM_SRC-1:0]       src_vec,
    input  logic [NUM_SRC*IDX_W-1:0] slots_flat,
    output logic [NUM_SRC-1:0]       slot_vec
);
    // bit n of slot_vec takes the source bit named by slot n; an index
    // outside the source range matches nothing and gives 0
    always_comb begin
        for (int n = 0; n < NUM_SRC; n++) begin
            slot_vec[n] = 1'b0;
            for (int s = 0; s < NUM_SRC; s++) begin
                if (slots_flat[n*IDX_W +: IDX_W] == IDX_W'(s)) begin
                    slot_vec[n] = src_vec[s];
                end
            end
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NUM_SRC = irq_prio_pkg::NUM_SRC,
    parameter int IDX_W   = irq_prio_pkg::IDX_W,
    parameter int DATA_W  = irq_prio_pkg::DATA_W
) (
    input  logic [NUM_SRC-1:0]       cand,
    input  logic [NUM_SRC*IDX_W-1:0] slots_flat,
    output logic [DATA_W-1:0]        offset
);
    import irq_prio_pkg::*;

    // ascending scan: the last hit is the highest slot
    always_comb begin
        offset = DATA_W'(NONE_CODE);
        for (int n = 0; n < NUM_SRC; n++) begin
            if (cand[n]) begin
                offset = DATA_W'({slots_flat[n*IDX_W +: IDX_W], 2'b00});
            end
        end
    end

endmodule

// File: rtl/irq_prio_bus.sv
module irq_prio_bus #(
    parameter int NUM_SRC = irq_prio_pkg::NUM_SRC,
    parameter int IDX_W   = irq_prio_pkg::IDX_W,
    parameter int ADDR_W  = irq_prio_pkg::ADDR_W,
    parameter int DATA_W  = irq_prio_pkg::DATA_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NUM_SRC*IDX_W-1:0] slots_flat,
    input  logic [NUM_SRC-1:0]       by_prio,
    input  logic [DATA_W-1:0]        off_all,
    input  logic [DATA_W-1:0]        off_fast,
    input  logic [DATA_W-1:0]        off_norm,
    output logic [DATA_W-1:0]        rdata,
    output logic                     rvalid
);
    import irq_prio_pkg::*;

    localparam int SLOTS_PER_WORD = DATA_W / LANE_W;
    localparam int NUM_WORDS      = (NUM_SRC + SLOTS_PER_WORD - 1) / SLOTS_PER_WORD;

    bus_state_e         state_q, state_d;
    logic [DATA_W-1:0]  rdata_q;
    logic [DATA_W-1:0]  rd_mux;
    logic [DATA_W-1:0]  slot_word [NUM_WORDS];

    // pack the slot fields into their words, unused lanes and bits zero
    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        for (genvar l = 0; l < SLOTS_PER_WORD; l++) begin : g_lane
            localparam int S = w * SLOTS_PER_WORD + l;
            if (S < NUM_SRC) begin : g_used
                assign slot_word[w][l*LANE_W +: LANE_W] =
                    LANE_W'(slots_flat[S*IDX_W +: IDX_W]);
            end else begin : g_empty
                assign slot_word[w][l*LANE_W +: LANE_W] = '0;
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (addr == ADDR_W'(A_SLOT_BASE + 4 * w)) begin
                rd_mux = slot_word[w];
            end
        end
        if (addr == ADDR_W'(A_OFF_ALL))  rd_mux = off_all;
        if (addr == ADDR_W'(A_BY_PRIO))  rd_mux = DATA_W'(by_prio);
        if (addr == ADDR_W'(A_OFF_FAST)) rd_mux = off_fast;
        if (addr == ADDR_W'(A_OFF_NORM)) rd_mux = off_norm;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: accept (IDLE->RESP), chain (RESP->RESP), release (RESP->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (rd_en) state_d = BUS_RESP;
            BUS_RESP: state_d = rd_en ? BUS_RESP : BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    // read data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_en) begin
            rdata_q <= rd_mux;
        end
    end

    // outputs
    always_comb begin
        rdata  = rdata_q;
        rvalid = 1'b0;
        unique case (state_q)
            BUS_IDLE: rvalid = 1'b0;
            BUS_RESP: rvalid = 1'b1;
            default:  rvalid = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
    parameter int NUM_SRC = irq_prio_pkg::NUM_SRC,
    parameter int IDX_W   = irq_prio_pkg::IDX_W,
    parameter int ADDR_W  = irq_prio_pkg::ADDR_W,
    parameter int DATA_W  = irq_prio_pkg::DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_pend_i,
    input  logic [NUM_SRC-1:0] src_fast_i,
    input  logic               bus_wr_i,
    input  logic               bus_rd_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               bus_rvalid_o
);
    import irq_prio_pkg::*;

    localparam int NUM_GRP = 3;

    logic [NUM_SRC*IDX_W-1:0] slots_flat;
    logic [NUM_SRC-1:0]       by_prio;
    logic [NUM_SRC-1:0]       fast_by_prio;
    logic [NUM_SRC-1:0]       cand [NUM_GRP];
    logic [DATA_W-1:0]        off  [NUM_GRP];
    logic [DATA_W-1:0]        off_all, off_fast, off_norm;

    irq_slot_regs #(
        .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_slots (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_wr_i),
        .addr       (bus_addr_i),
        .wdata      (bus_wdata_i),
        .slots_flat (slots_flat)
    );

    irq_prio_reorder #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_reo_pend (
        .src_vec    (src_pend_i),
        .slots_flat (slots_flat),
        .slot_vec   (by_prio)
    );

    irq_prio_reorder #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_reo_mode (
        .src_vec    (src_fast_i),
        .slots_flat (slots_flat),
        .slot_vec   (fast_by_prio)
    );

    // reordering is bitwise, so group selection can follow it
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        if (g == int'(GRP_ALL)) begin : g_all
            assign cand[g] = by_prio;
        end else if (g == int'(GRP_FAST)) begin : g_fast
            assign cand[g] = by_prio & fast_by_prio;
        end else begin : g_norm
            assign cand[g] = by_prio & ~fast_by_prio;
        end

        irq_prio_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_pick (
            .cand       (cand[g]),
            .slots_flat (slots_flat),
            .offset     (off[g])
        );
    end

    assign off_all  = off[int'(GRP_ALL)];
    assign off_fast = off[int'(GRP_FAST)];
    assign off_norm = off[int'(GRP_NORM)];

    irq_prio_bus #(
        .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_bus (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (bus_rd_i),
        .addr       (bus_addr_i),
        .slots_flat (slots_flat),
        .by_prio    (by_prio),
        .off_all    (off_all),
        .off_fast   (off_fast),
        .off_norm   (off_norm),
        .rdata      (bus_rdata_o),
        .rvalid     (bus_rvalid_o)
    );

endmodule

// File: rtl/irq_prio_resolver_chk.sv
module irq_prio_resolver_chk #(
    parameter int NUM_SRC = irq_prio_pkg::NUM_SRC,
    parameter int IDX_W   = irq_prio_pkg::IDX_W,
    parameter int DATA_W  = irq_prio_pkg::DATA_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_pend_i,
    input logic [NUM_SRC-1:0] src_fast_i,
    input logic               bus_rd_i,
    input logic [DATA_W-1:0]  bus_rdata_o,
    input logic               bus_rvalid_o,
    input logic [NUM_SRC-1:0] by_prio,
    input logic [DATA_W-1:0]  off_all,
    input logic [DATA_W-1:0]  off_fast,
    input logic [DATA_W-1:0]  off_norm
);
    import irq_prio_pkg::*;

    localparam logic [DATA_W-1:0] NONE = DATA_W'(NONE_CODE);

    logic [IDX_W-1:0] fast_idx, norm_idx;
    assign fast_idx = off_fast[IDX_W+1:2];
    assign norm_idx = off_norm[IDX_W+1:2];

    a_r8_rvalid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_i |=> bus_rvalid_o);

    a_r8_rvalid_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid_o |-> $past(bus_rd_i));

    a_r8_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd_i) |-> $stable(bus_rdata_o));

    a_r5_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
        (src_pend_i == '0) |-> (off_all == NONE && off_fast == NONE && off_norm == NONE));

    a_r3_reorder_vs_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (by_prio == '0) == (off_all == NONE));

    a_r6_fast_winner_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (off_fast != NONE) |-> (src_fast_i[fast_idx] && src_pend_i[fast_idx]));

    a_r6_norm_winner_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (off_norm != NONE) |-> (!src_fast_i[norm_idx] && src_pend_i[norm_idx]));

    a_r4_all_from_group: assert property (@(posedge clk) disable iff (!rst_n)
        (off_all != NONE) |-> (off_all == off_fast || off_all == off_norm));

endmodule

bind irq_prio_resolver irq_prio_resolver_chk #(
    .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .DATA_W(DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_pend_i   (src_pend_i),
    .src_fast_i   (src_fast_i),
    .bus_rd_i     (bus_rd_i),
    .bus_rdata_o  (bus_rdata_o),
    .bus_rvalid_o (bus_rvalid_o),
    .by_prio      (by_prio),
    .off_all      (off_all),
    .off_fast     (off_fast),
    .off_norm     (off_norm)
);

// File: tb/irq_prio_resolver_tb.sv
module irq_prio_resolver_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 21;
    localparam int NW   = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [20:0] pend = '0;
    logic [20:0] fast = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rvalid;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;
    logic [4:0] slot_m [NSRC];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_resolver dut_i (
        .clk(clk), .rst_n(rst_n), .src_pend_i(pend), .src_fast_i(fast),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .bus_rvalid_o(rvalid)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(int w);
        logic [31:0] v = '0;
        for (int l = 0; l < 4; l++)
            if (w*4 + l < NSRC) v[l*8 +: 8] = {3'b000, slot_m[w*4 + l]};
        return v;
    endfunction

    function automatic logic [31:0] exp_reorder(logic [20:0] p);
        logic [31:0] v = '0;
        for (int n = 0; n < NSRC; n++)
            if (int'(slot_m[n]) < NSRC) v[n] = p[slot_m[n]];
        return v;
    endfunction

    function automatic logic [31:0] exp_off(logic [20:0] p, logic [20:0] sel);
        logic [31:0] v = 32'h54;
        for (int n = 0; n < NSRC; n++)
            if (int'(slot_m[n]) < NSRC && p[slot_m[n]] && sel[slot_m[n]])
                v = {25'd0, slot_m[n], 2'b00};
        return v;
    endfunction

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
        for (int w = 0; w < NW; w++)
            if (a == 8'(12 + 4*w))
                for (int l = 0; l < 4; l++)
                    if (w*4 + l < NSRC) slot_m[w*4 + l] = d[l*8 +: 5];
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        d = rdata; v = rvalid;
    endtask

    task automatic check_results(string tag);
        logic [31:0] d; logic v;
        bus_read(8'h24, d, v); check({tag, " R4 combined offset"}, d, exp_off(pend, '1));
        bus_read(8'h28, d, v); check({tag, " R3 reordered pending"}, d, exp_reorder(pend));
        bus_read(8'h30, d, v); check({tag, " R6 fast offset"}, d, exp_off(pend, fast));
        bus_read(8'h34, d, v); check({tag, " R6 normal offset"}, d, exp_off(pend, ~fast));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d; logic v;
        void'($urandom(32'h5EED_1234));
        for (int n = 0; n < NSRC; n++) slot_m[n] = 5'(n);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R8 / R1: reset state
        check("R8 rvalid low after reset", 32'(rvalid), 32'd0);
        for (int w = 0; w < NW; w++) begin
            bus_read(8'(12 + 4*w), d, v);
            check("R1 slot word reset value", d, exp_word(w));
        end
        bus_read(8'h0C, d, v); check("R1 literal word 0", d, 32'h03020100);
        bus_read(8'h20, d, v); check("R1 literal word 5", d, 32'h00000014);
        check("R8 rvalid after read", 32'(v), 32'd1);
        @(negedge clk);
        check("R8 rvalid single pulse", 32'(rvalid), 32'd0);

        // R5: nothing pending, then lone source 0
        pend = '0; fast = '0;
        check_results("R5 empty");
        bus_read(8'h24, d, v); check("R5 no-pending code", d, 32'h54);
        pend = 21'h1;
        bus_read(8'h24, d, v); check("R5 lone source 0 gives 0", d, 32'h0);
        bus_read(8'h30, d, v); check("R5 fast group empty", d, 32'h54);

        // R2: field width and lane placement
        bus_write(8'h0C, 32'hFFFF_FFFF);
        bus_read(8'h0C, d, v); check("R2 only 5 bits kept", d, 32'h1F1F1F1F);
        bus_write(8'h20, 32'hFFFF_FFE3);
        bus_read(8'h20, d, v); check("R2 word 5 holds slot 20 only", d, 32'h00000003);
        bus_write(8'h0C, 32'h03020100);
        bus_write(8'h20, 32'h00000014);

        // R7: duplicates and out-of-range
        bus_write(8'h20, 32'h00000002);          // slot 20 -> source 2
        bus_write(8'h1C, 32'h02121110);          // slot 19 -> source 2 too
        pend = 21'h0C_0004; fast = 21'h0;        // sources 2, 18, 19
        bus_read(8'h24, d, v); check("R7 duplicate higher slot wins", d, 32'h08);
        bus_write(8'h20, 32'h0000001F);          // slot 20 out of range
        bus_write(8'h1C, 32'h1E121110);          // slot 19 out of range
        bus_read(8'h24, d, v); check("R7 out-of-range never wins", d, 32'h48);
        bus_read(8'h28, d, v); check("R7 out-of-range reorder bits", d, exp_reorder(pend));
        check_results("R7 directed");

        // R8: read-only and unmapped accesses
        bus_write(8'h24, 32'h0);
        bus_write(8'h40, 32'h0);
        for (int w = 0; w < NW; w++) begin
            bus_read(8'(12 + 4*w), d, v);
            check("R8 read-only write ignored", d, exp_word(w));
        end
        bus_read(8'h40, d, v); check("R8 unmapped reads zero", d, 32'h0);
        bus_read(8'h04, d, v); check("R8 unmapped low reads zero", d, 32'h0);

        // R4 / R6 / R3: random maps and vectors
        for (int it = 0; it < 60; it++) begin
            if (it % 3 == 0) begin
                for (int w = 0; w < NW; w++) begin
                    logic [31:0] nd;
                    for (int l = 0; l < 4; l++)
                        nd[l*8 +: 8] = ($urandom % 5 == 0) ? 8'($urandom) : 8'($urandom % 21);
                    bus_write(8'(12 + 4*w), nd);
                end
            end
            pend = 21'($urandom) & 21'($urandom);
            fast = 21'($urandom);
            check_results("random");
        end
        bus_read(8'h10, d, v); check("R2 random word readback", d, exp_word(1));

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule